// File: doc/BRIEF.md
# SPI Serial Hold Pause Controller

This block sits beside the command engine of an SPI slave. It lets the host pause a transfer without deselecting the device. It watches the chip-select, serial-clock and pause inputs, which are already synchronised to the system clock, and produces three kinds of output:

- a registered hold flag;
- an enable mask for the serial data output driver;
- qualified serial-clock edge strobes that the shift logic uses in place of raw edges.

While the pause is in force, the edge strobes are withheld. The bit counter and shift registers downstream therefore freeze and continue from the same bit once the pause ends.

A pause only starts or ends while the serial clock is low. A request made while the clock is high waits for the next clock falling edge. Deselecting the device during a pause clears the hold at once and raises a one-cycle abort strobe, so the engine can drop the unfinished transaction. A new selection always starts out of hold.

Top module: `spi_hold_ctrl`

## Requirements
- R1: After synchronous reset, hold_active, so_enable_mask, sck_rise_ok, sck_fall_ok and cs_abort are all 0.
- R2: With cs_n low, sampling hold_n low while sck is low sets hold_active to 1 one clock later.
- R3: While hold_active is 0, sampling sck high keeps hold_active at 0 on the next clock, whatever hold_n is. The pause starts only once sck is sampled low with hold_n still low.
- R4: Sampling hold_n high while sck is low clears hold_active one clock later.
- R5: While hold_active is 1 and cs_n is low, sampling sck high keeps hold_active at 1 on the next clock, whatever hold_n is.
- R6: Sampling cs_n high clears hold_active one clock later, and also clears so_enable_mask.
- R7: so_enable_mask is 1 exactly when the last sampled cs_n was low and hold_active is 0 in the same cycle.
- R8: sck_rise_ok (sck_fall_ok) pulses for one clock one cycle after a low-to-high (high-to-low) change of sampled sck, but only if hold_active is 0 both before and after that sample.
- R9: cs_abort pulses for one clock one cycle after cs_n is sampled rising while hold_active is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Synchronised chip select, active low |
| sck | input | 1 | Synchronised serial clock level |
| hold_n | input | 1 | Synchronised pause request, active low |
| hold_active | output | 1 | Registered pause state |
| so_enable_mask | output | 1 | 1 allows the serial output driver to be enabled |
| sck_rise_ok | output | 1 | Qualified serial-clock rising-edge strobe |
| sck_fall_ok | output | 1 | Qualified serial-clock falling-edge strobe |
| cs_abort | output | 1 | Deselect-during-pause strobe |

## Verification
The assertions and checks assume the three inputs are already synchronous to clk. They also assume each serial-clock level lasts at least one system clock, so every edge is seen as a change between two samples. Finally, they assume sck rests at its idle level through reset, so no phantom edge appears at the first sample.

The stimulus changes inputs only between clock edges, one step per clock, and keeps sck low during reset. It then sweeps a pseudo-random walk over all eight input combinations, with chip select low most of the time. A directed prologue exercises each entry and exit ordering against the clock level before the sweep begins.

// File: rtl/spi_hold_pkg.sv
package spi_hold_pkg;
  typedef struct packed {
    logic rise;
    logic fall;
    logic desel;
  } edge_flags_t;
endpackage

// File: rtl/spi_hold_edge.sv
module spi_hold_edge #(
  parameter logic SCK_IDLE = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic sck,
  input  logic cs_n,
  output spi_hold_pkg::edge_flags_t flags
);
  logic sck_q;
  logic cs_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_q <= SCK_IDLE;
      cs_q  <= 1'b1;
    end else begin
      sck_q <= sck;
      cs_q  <= cs_n;
    end
  end

  always_comb begin
    flags.rise  = ~sck_q & sck;
    flags.fall  = sck_q & ~sck;
    flags.desel = ~cs_q & cs_n;
  end
endmodule

// File: rtl/spi_hold_state.sv
module spi_hold_state (
  input  logic clk,
  input  logic rst,
  input  logic cs_n,
  input  logic sck,
  input  logic hold_n,
  output logic hold_q,
  output logic hold_nxt
);
  // A pause may only change while the serial clock is low.
  always_comb begin
    if (cs_n)     hold_nxt = 1'b0;
    else if (sck) hold_nxt = hold_q;
    else          hold_nxt = ~hold_n;
  end

  always_ff @(posedge clk) begin
    if (rst) hold_q <= 1'b0;
    else     hold_q <= hold_nxt;
  end

  AST_ENTER_LOW: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && !sck && !hold_n) |=> hold_q); // R2
  AST_NO_ENTRY_HIGH: assert property (@(posedge clk) disable iff (rst)
    (!hold_q && sck) |=> !hold_q); // R3
  AST_EXIT_LOW: assert property (@(posedge clk) disable iff (rst)
    (!sck && hold_n) |=> !hold_q); // R4
  AST_NO_EXIT_HIGH: assert property (@(posedge clk) disable iff (rst)
    (hold_q && sck && !cs_n) |=> hold_q); // R5
  AST_DESELECT_CLEARS: assert property (@(posedge clk) disable iff (rst)
    cs_n |=> !hold_q); // R6
endmodule

// File: rtl/spi_hold_ctrl.sv
module spi_hold_ctrl #(
  parameter logic SCK_IDLE = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic cs_n,
  input  logic sck,
  input  logic hold_n,
  output logic hold_active,
  output logic so_enable_mask,
  output logic sck_rise_ok,
  output logic sck_fall_ok,
  output logic cs_abort
);
  spi_hold_pkg::edge_flags_t flags;
  logic hold_q;
  logic hold_nxt;
  logic quiet;

  spi_hold_edge #(.SCK_IDLE(SCK_IDLE)) edge_i (
    .clk(clk), .rst(rst), .sck(sck), .cs_n(cs_n), .flags(flags)
  );

  spi_hold_state state_i (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .hold_n(hold_n),
    .hold_q(hold_q), .hold_nxt(hold_nxt)
  );

  // An edge counts only if no pause surrounds it.
  assign quiet = ~hold_q & ~hold_nxt;

  always_ff @(posedge clk) begin
    if (rst) begin
      so_enable_mask <= 1'b0;
      sck_rise_ok    <= 1'b0;
      sck_fall_ok    <= 1'b0;
      cs_abort       <= 1'b0;
    end else begin
      so_enable_mask <= ~cs_n & ~hold_nxt;
      sck_rise_ok    <= flags.rise & quiet;
      sck_fall_ok    <= flags.fall & quiet;
      cs_abort       <= flags.desel & hold_q;
    end
  end

  assign hold_active = hold_q;

  AST_SO_MASKED: assert property (@(posedge clk) disable iff (rst)
    hold_active |-> !so_enable_mask); // R7
  AST_EDGE_BLOCKED: assert property (@(posedge clk) disable iff (rst)
    (sck_rise_ok || sck_fall_ok) |-> !hold_active); // R8
  AST_EDGE_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    $countones({sck_rise_ok, sck_fall_ok}) <= 1); // R8
  AST_ABORT_PULSE: assert property (@(posedge clk) disable iff (rst)
    cs_abort |=> !cs_abort); // R9
  AST_ABORT_DESELECTED: assert property (@(posedge clk) disable iff (rst)
    cs_abort |-> (!hold_active && !so_enable_mask)); // R9
endmodule

// File: tb/spi_hold_ctrl_tb.sv
module spi_hold_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1, sck = 1'b0, hold_n = 1'b1;
  logic hold_active, so_enable_mask, sck_rise_ok, sck_fall_ok, cs_abort;
  int n_chk = 0, n_bad = 0;
  logic m_hold, m_sck, m_cs;
  logic e_hold, e_so, e_rise, e_fall, e_abort;
  string htag;

  always #2.5 clk = ~clk;

  spi_hold_ctrl dut_i (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .hold_n(hold_n),
    .hold_active(hold_active), .so_enable_mask(so_enable_mask),
    .sck_rise_ok(sck_rise_ok), .sck_fall_ok(sck_fall_ok), .cs_abort(cs_abort)
  );

  task automatic chk(input logic act, input logic exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // Apply inputs at a falling clock edge; compute the expected outputs for the next sample.
  task automatic step(input logic c, input logic h, input logic s);
    logic nh;
    cs_n = c; hold_n = h; sck = s;
    if (c)      htag = "R6";
    else if (s) htag = m_hold ? "R5" : "R3";
    else        htag = h ? "R4" : "R2";
    nh = c ? 1'b0 : (s ? m_hold : ~h);
    e_hold  = nh;
    e_so    = ~c & ~nh;
    e_rise  = ~m_sck & s & ~m_hold & ~nh;
    e_fall  = m_sck & ~s & ~m_hold & ~nh;
    e_abort = ~m_cs & c & m_hold;
    m_hold = nh; m_sck = s; m_cs = c;
    @(negedge clk);
    chk(hold_active, e_hold, htag);
    chk(so_enable_mask, e_so, "R7");
    chk(sck_rise_ok, e_rise, "R8");
    chk(sck_fall_ok, e_fall, "R8");
    chk(cs_abort, e_abort, "R9");
  endtask

  initial begin
    #1000000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    m_hold = 1'b0; m_sck = 1'b0; m_cs = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk(hold_active, 1'b0, "R1"); chk(so_enable_mask, 1'b0, "R1");
    chk(sck_rise_ok, 1'b0, "R1"); chk(sck_fall_ok, 1'b0, "R1");
    chk(cs_abort, 1'b0, "R1");
    // Directed: select, clock, pause with sck low (R2), release low (R4)
    step(0,1,0); step(0,1,1); step(0,1,0);
    step(0,0,0); step(0,0,1); step(0,0,0); step(0,1,0);
    // Pause requested while sck high (R3), starts at falling edge
    step(0,1,1); step(0,0,1); step(0,0,1); step(0,0,0);
    // Release while sck high (R5), ends at falling edge
    step(0,0,1); step(0,1,1); step(0,1,1); step(0,1,0); step(0,1,1);
    // Deselect during pause (R6, R9)
    step(0,1,0); step(0,0,0); step(1,0,0); step(1,0,0); step(0,0,0);
    step(0,1,0);
    // Near-exhaustive sweep over the input space
    lfsr = 16'hACE1;
    for (int i = 0; i < 6000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[2:0] == 3'b000, lfsr[5], lfsr[8]);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule